// File: doc/BRIEF.md
# External Memory Cycle Sequencer

This block turns one request from a 16-bit processor core into one external read or write cycle. It advances once per clock, and each clock stands for one TCL step (half a CPU clock period). Each request brings its own address, write data, direction, data width and a set of cycle settings. The settings are an address-latch lengthening bit, a command delay bit, a 4-bit cycle-time field that gives the waitstate count, a tristate-time field, a READY enable bit and a bit that picks a demultiplexed or a multiplexed address/data bus. The block drives the latch strobe, the active-low read, write and select strobes, a separate address bus, the shared address/data lines with one output enable per byte lane, and it returns read data with a one-step done pulse.

A cycle is a fixed chain of phases: optional address setup, the latch-high phase, an optional command gap, the strobe window and a tail. Each setting lengthens one of these phases by a fixed amount. The settings are latched when the request is accepted, so one cycle can differ from the next. Requests use a valid/ready handshake and are held off while a cycle runs.

Top module: `ebc_sequencer`

## Requirements
- R1: While reset is applied, the latch strobe is low, the read, write and select strobes are high and every lane output enable is off. After release, req_ready is high, done_o is low and rdata_o is zero.
- R2: With the lengthening bit 0, the command delay bit 0, a cycle-time field of 15 and a tristate field of 0, a cycle occupies 6 steps on the multiplexed bus and 4 steps on the demultiplexed bus. This is counted from the accepting edge to the return of req_ready.
- R3: The cycle length in steps is the base length plus twice the lengthening bit, plus the waitstate steps, plus the tristate field value. req_ready stays low for exactly that many steps.
- R4: The latch strobe is high for 1 step, or 2 steps when lengthened. A lengthened cycle first spends 1 step with the address driven and the latch strobe low. No select, read or write strobe is low while the latch strobe is high.
- R5: The waitstate count is 15 minus the cycle-time field, and each waitstate adds 2 steps to the strobe window.
- R6: Without command delay, the read or write strobe falls in the step after the latch strobe falls and stays low for 3 steps plus the waitstate steps. With command delay, it falls one step later and stays low for 2 steps plus the waitstate steps. Read and write are never low together.
- R7: The select strobe is low from the step after the latch strobe falls up to and including the last strobe step.
- R8: On the multiplexed bus, both lanes drive address bits 15:0 during the setup and latch phases, and all lane enables are off whenever the read strobe is low. On the demultiplexed bus, the shared lines are not driven in the address phases. addr_o holds the request address from acceptance until the next acceptance.
- R9: Read data is taken from ad_i at the edge that ends the last read-strobe step. In 8-bit mode rdata_o is {8'h00, ad_i[7:0]}.
- R10: For a write, the shared lines carry the write data from the first write-strobe step through one step after the write strobe rises, or up to the end of the cycle if that comes first. In 8-bit mode only lane 0 (bits 7:0) is enabled and driven.
- R11: With the READY enable set, ready_i is sampled at the edge that would end the strobe window. If it is low there, the window grows by 2 steps and ready_i is sampled again. With the enable clear, ready_i has no effect.
- R12: A request is accepted only on an edge where req_valid and req_ready are both high. Request and setting inputs that change during a cycle have no effect on that cycle.
- R13: done_o is high for exactly the one step that follows the last step of a cycle. In that step req_ready is high and rdata_o holds the result of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock, one period per TCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_bus8 | input | 1 | 1 = 8-bit data width |
| cfg_ale_ext | input | 1 | Latch phase lengthening |
| cfg_cmd_dly | input | 1 | Command delay enable |
| cfg_cyc_time | input | CT_W | Cycle-time field, waitstates = 15 - value |
| cfg_tri_time | input | TF_W | Tristate steps added after the strobe |
| cfg_rdy_en | input | 1 | Synchronous READY enable |
| cfg_demux | input | 1 | 1 = separate address bus |
| ready_i | input | 1 | Synchronous READY from the device |
| ale_o | output | 1 | Address latch strobe, active high |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| cs_n_o | output | 1 | Chip select, active low |
| addr_o | output | AW | Separate address bus |
| ad_o | output | DW | Shared address/data output value |
| ad_oe_o | output | DW/8 | Output enable per byte lane |
| ad_i | input | DW | Shared address/data input value |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | One-step cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 16-bit data in two byte lanes, a 4-bit cycle-time field and a 2-bit tristate field. With these values a single cycle can span anything from the bare 4-step demultiplexed form to several tens of steps. The tests cover both bus modes, both data widths, the lengthened latch phase, the command gap, nonzero waitstate counts, tristate tails up to 3 steps and READY stalls. The 4-bit field lets a test combine waitstates with READY stalls in one strobe window, and the 2-bit tristate field makes a tail of zero steps possible. That zero-step tail in demultiplexed mode is the corner where the write hold must stop at the end of the cycle.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

  // Phases of one external cycle, in the order they occur.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_ALE   = 3'd2,
    PH_GAP   = 3'd3,
    PH_STRB  = 3'd4,
    PH_TAIL  = 3'd5
  } phase_e;

endpackage

// File: rtl/ebc_fsm.sv
module ebc_fsm
  import ebc_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int CT_W  = 4,
  parameter int TF_W  = 2,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_write,
  input  logic             req_bus8,
  input  logic             cfg_ale_ext,
  input  logic             cfg_cmd_dly,
  input  logic [CT_W-1:0]  cfg_cyc_time,
  input  logic [TF_W-1:0]  cfg_tri_time,
  input  logic             cfg_rdy_en,
  input  logic             cfg_demux,
  input  logic             ready_i,
  output phase_e           phase,
  output logic             tail_first,
  output logic             strb_end,
  output logic             cyc_end,
  output logic             req_ready,
  output logic [AW-1:0]    lat_addr,
  output logic [DW-1:0]    lat_wdata,
  output logic             lat_write,
  output logic             lat_bus8,
  output logic             lat_demux
);

  localparam int CT_MAX = (1 << CT_W) - 1;

  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               tfirst_q, tfirst_d;
  logic               load;

  logic               alex_q, dly_q, rdy_q;
  logic [CT_W-1:0]    ct_q;
  logic [TF_W-1:0]    tf_q;

  function automatic logic [CNT_W-1:0] phase_len(
    input phase_e          ph,
    input logic            alex,
    input logic            dly,
    input logic [CT_W-1:0] ct,
    input logic [TF_W-1:0] tf,
    input logic            demux
  );
    int n;
    case (ph)
      PH_SETUP: n = alex ? 1 : 0;
      PH_ALE:   n = alex ? 2 : 1;
      PH_GAP:   n = 1;
      PH_STRB:  n = (dly ? 2 : 3) + 2 * (CT_MAX - int'(ct));
      PH_TAIL:  n = (demux ? 0 : 2) + int'(tf);
      default:  n = 0;
    endcase
    return CNT_W'(n);
  endfunction

  assign req_ready = (phase_q == PH_IDLE) && rst_n;
  assign load      = req_valid && req_ready;

  // Next-state process
  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    tfirst_d = 1'b0;
    strb_end = 1'b0;
    cyc_end  = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (load) begin
        phase_d = cfg_ale_ext ? PH_SETUP : PH_ALE;
        cnt_d   = phase_len(phase_d, cfg_ale_ext, cfg_cmd_dly, cfg_cyc_time,
                            cfg_tri_time, cfg_demux) - CNT_W'(1);
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else if (phase_q == PH_STRB && rdy_q && !ready_i) begin
      cnt_d = CNT_W'(1);
    end else begin
      case (phase_q)
        PH_SETUP: phase_d = PH_ALE;
        PH_ALE:   phase_d = dly_q ? PH_GAP : PH_STRB;
        PH_GAP:   phase_d = PH_STRB;
        PH_STRB:  phase_d = (phase_len(PH_TAIL, alex_q, dly_q, ct_q, tf_q, lat_demux) != '0)
                            ? PH_TAIL : PH_IDLE;
        default:  phase_d = PH_IDLE;
      endcase
      strb_end = (phase_q == PH_STRB);
      if (phase_d == PH_IDLE) begin
        cyc_end = 1'b1;
        cnt_d   = '0;
      end else begin
        cnt_d    = phase_len(phase_d, alex_q, dly_q, ct_q, tf_q, lat_demux) - CNT_W'(1);
        tfirst_d = (phase_d == PH_TAIL);
      end
    end
  end

  // Phase register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      tfirst_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      tfirst_q <= tfirst_d;
    end
  end

  // Request and settings latch, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_write <= 1'b0;
      lat_bus8  <= 1'b0;
      lat_demux <= 1'b0;
      alex_q    <= 1'b0;
      dly_q     <= 1'b0;
      rdy_q     <= 1'b0;
      ct_q      <= '0;
      tf_q      <= '0;
    end else if (load) begin
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
      lat_write <= req_write;
      lat_bus8  <= req_bus8;
      lat_demux <= cfg_demux;
      alex_q    <= cfg_ale_ext;
      dly_q     <= cfg_cmd_dly;
      rdy_q     <= cfg_rdy_en;
      ct_q      <= cfg_cyc_time;
      tf_q      <= cfg_tri_time;
    end
  end

  assign phase      = phase_q;
  assign tail_first = tfirst_q;

endmodule

// File: rtl/ebc_pins.sv
module ebc_pins
  import ebc_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int LANES = DW / 8
) (
  input  phase_e            phase,
  input  logic              tail_first,
  input  logic [AW-1:0]     lat_addr,
  input  logic [DW-1:0]     lat_wdata,
  input  logic              lat_write,
  input  logic              lat_bus8,
  input  logic              lat_demux,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              cs_n_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     ad_o,
  output logic [LANES-1:0]  ad_oe_o
);

  logic in_strb;
  logic addr_phase;
  logic wdrv;

  assign in_strb    = (phase == PH_STRB);
  assign addr_phase = ((phase == PH_SETUP) || (phase == PH_ALE)) && !lat_demux;
  assign wdrv       = lat_write && (in_strb || ((phase == PH_TAIL) && tail_first));

  assign ale_o  = (phase == PH_ALE);
  assign cs_n_o = !((phase == PH_GAP) || in_strb);
  assign rd_n_o = !(in_strb && !lat_write);
  assign wr_n_o = !(in_strb && lat_write);
  assign addr_o = lat_addr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit LOW_LANE = (g == 0);
    logic data_on;
    assign data_on = wdrv && (LOW_LANE || !lat_bus8);
    assign ad_oe_o[g] = addr_phase || data_on;
    assign ad_o[g*8 +: 8] = addr_phase ? lat_addr[g*8 +: 8] :
                            data_on    ? lat_wdata[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/ebc_capture.sv
module ebc_capture #(
  parameter int DW    = 16,
  parameter int LANES = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strb_end,
  input  logic          cyc_end,
  input  logic          lat_write,
  input  logic          lat_bus8,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o
);

  logic take;
  assign take = strb_end && !lat_write;

  for (genvar g = 0; g < LANES; g++) begin : g_cap
    localparam bit LOW_LANE = (g == 0);
    logic [7:0] lane_d;
    assign lane_d = (LOW_LANE || !lat_bus8) ? ad_i[g*8 +: 8] : 8'h00;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_o[g*8 +: 8] <= 8'h00;
      else if (take) rdata_o[g*8 +: 8] <= lane_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_o <= 1'b0;
    else        done_o <= cyc_end;
  end

endmodule

// File: rtl/ebc_sequencer.sv
module ebc_sequencer
  import ebc_pkg::*;
#(
  parameter int AW   = 24,
  parameter int DW   = 16,
  parameter int CT_W = 4,
  parameter int TF_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              req_write,
  input  logic              req_bus8,
  input  logic              cfg_ale_ext,
  input  logic              cfg_cmd_dly,
  input  logic [CT_W-1:0]   cfg_cyc_time,
  input  logic [TF_W-1:0]   cfg_tri_time,
  input  logic              cfg_rdy_en,
  input  logic              cfg_demux,
  input  logic              ready_i,
  output logic              ale_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              cs_n_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     ad_o,
  output logic [DW/8-1:0]   ad_oe_o,
  input  logic [DW-1:0]     ad_i,
  output logic [DW-1:0]     rdata_o,
  output logic              done_o
);

  localparam int LANES  = DW / 8;
  localparam int WS_MAX = (1 << CT_W) - 1;
  localparam int CNT_W  = $clog2(3 + 2 * WS_MAX + (1 << TF_W) + 2);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  phase_e           phase;
  logic             tail_first, strb_end, cyc_end;
  logic [AW-1:0]    lat_addr;
  logic [DW-1:0]    lat_wdata;
  logic             lat_write, lat_bus8, lat_demux;

  ebc_fsm #(
    .AW(AW), .DW(DW), .CT_W(CT_W), .TF_W(TF_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_write   (req_write),
    .req_bus8    (req_bus8),
    .cfg_ale_ext (cfg_ale_ext),
    .cfg_cmd_dly (cfg_cmd_dly),
    .cfg_cyc_time(cfg_cyc_time),
    .cfg_tri_time(cfg_tri_time),
    .cfg_rdy_en  (cfg_rdy_en),
    .cfg_demux   (cfg_demux),
    .ready_i     (ready_i),
    .phase       (phase),
    .tail_first  (tail_first),
    .strb_end    (strb_end),
    .cyc_end     (cyc_end),
    .req_ready   (req_ready),
    .lat_addr    (lat_addr),
    .lat_wdata   (lat_wdata),
    .lat_write   (lat_write),
    .lat_bus8    (lat_bus8),
    .lat_demux   (lat_demux)
  );

  ebc_pins #(.AW(AW), .DW(DW), .LANES(LANES)) u_pins (
    .phase     (phase),
    .tail_first(tail_first),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .lat_write (lat_write),
    .lat_bus8  (lat_bus8),
    .lat_demux (lat_demux),
    .ale_o     (ale_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .cs_n_o    (cs_n_o),
    .addr_o    (addr_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o)
  );

  ebc_capture #(.DW(DW), .LANES(LANES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strb_end (strb_end),
    .cyc_end  (cyc_end),
    .lat_write(lat_write),
    .lat_bus8 (lat_bus8),
    .ad_i     (ad_i),
    .rdata_o  (rdata_o),
    .done_o   (done_o)
  );

endmodule

// File: rtl/ebc_sequencer_chk.sv
module ebc_sequencer_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             ale_o,
  input logic             rd_n_o,
  input logic             wr_n_o,
  input logic             cs_n_o,
  input logic [LANES-1:0] ad_oe_o,
  input logic             done_o
);

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  p_cs_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_o || !wr_n_o) |-> !cs_n_o);

  p_ale_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (cs_n_o && rd_n_o && wr_n_o));

  p_mux_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> (ad_oe_o == '0));

  p_one_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (req_ready && cs_n_o && rd_n_o && wr_n_o));

endmodule

bind ebc_sequencer ebc_sequencer_chk #(.LANES(DW/8)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .ale_o    (ale_o),
  .rd_n_o   (rd_n_o),
  .wr_n_o   (wr_n_o),
  .cs_n_o   (cs_n_o),
  .ad_oe_o  (ad_oe_o),
  .done_o   (done_o)
);

// File: tb/tb_ebc_sequencer.sv
module tb_ebc_sequencer;
  localparam int AW = 24, DW = 16, CT_W = 4, TF_W = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n;
  logic            req_valid, req_ready;
  logic [AW-1:0]   req_addr;
  logic [DW-1:0]   req_wdata;
  logic            req_write, req_bus8;
  logic            cfg_ale_ext, cfg_cmd_dly, cfg_rdy_en, cfg_demux;
  logic [CT_W-1:0] cfg_cyc_time;
  logic [TF_W-1:0] cfg_tri_time;
  logic            ready_i;
  logic            ale_o, rd_n_o, wr_n_o, cs_n_o;
  logic [AW-1:0]   addr_o;
  logic [DW-1:0]   ad_o, ad_i, rdata_o;
  logic [1:0]      ad_oe_o;
  logic            done_o;

  ebc_sequencer #(.AW(AW), .DW(DW), .CT_W(CT_W), .TF_W(TF_W)) dut (.*);

  int errors = 0;
  int checks = 0;
  logic [15:0] last_rdata;

  typedef struct {
    bit          ale, rd_n, wr_n, cs_n;
    bit [1:0]    oe;
    logic [15:0] ad;
    int          sidx;
  } step_t;

  step_t exp_q[$];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic step_t mk(bit ale, bit rd_n, bit wr_n, bit cs_n,
                               bit [1:0] oe, logic [15:0] ad, int sidx);
    step_t s;
    s.ale = ale; s.rd_n = rd_n; s.wr_n = wr_n; s.cs_n = cs_n;
    s.oe = oe; s.ad = ad; s.sidx = sidx;
    return s;
  endfunction

  // One cycle against a behavioural step-by-step model.
  task automatic run_cycle(input bit wr, input bit b8, input bit alex, input bit dly,
                           input logic [3:0] ct, input logic [1:0] tf,
                           input bit rdy, input bit demux, input int stall,
                           input logic [23:0] addr, input logic [15:0] wd,
                           input logic [15:0] rv);
    int tc, l0, lf, tail, n;
    bit [1:0] aoe;
    logic [15:0] aval, wval;
    tc   = 2 * (15 - int'(ct));                 // R5
    l0   = (dly ? 2 : 3) + tc;                  // R6
    lf   = l0 + (rdy ? 2 * stall : 0);          // R11
    tail = (demux ? 0 : 2) + int'(tf);          // R2 base, R3 tristate
    aoe  = demux ? 2'b00 : 2'b11;
    aval = demux ? 16'h0000 : addr[15:0];
    wval = b8 ? {8'h00, wd[7:0]} : wd;
    exp_q.delete();
    for (int i = 0; i < int'(alex); i++) exp_q.push_back(mk(0, 1, 1, 1, aoe, aval, -1));
    for (int i = 0; i < 1 + int'(alex); i++) exp_q.push_back(mk(1, 1, 1, 1, aoe, aval, -1));
    if (dly) exp_q.push_back(mk(0, 1, 1, 0, 2'b00, 16'h0000, -1));
    for (int i = 0; i < lf; i++)
      exp_q.push_back(mk(0, wr, !wr, 0, wr ? (b8 ? 2'b01 : 2'b11) : 2'b00,
                         wr ? wval : 16'h0000, i));
    for (int i = 0; i < tail; i++)
      exp_q.push_back(mk(0, 1, 1, 1, (wr && i == 0) ? (b8 ? 2'b01 : 2'b11) : 2'b00,
                         (wr && i == 0) ? wval : 16'h0000, -1));
    n = exp_q.size();

    @(negedge clk);
    chk("R13", "done after idle step", 32'(done_o), 32'd0);
    chk("R12", "req_ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = addr; req_wdata = wd; req_write = wr; req_bus8 = b8;
    cfg_ale_ext = alex; cfg_cmd_dly = dly; cfg_cyc_time = ct; cfg_tri_time = tf;
    cfg_rdy_en = rdy; cfg_demux = demux; ready_i = 1'b0; ad_i = ~rv;
    @(posedge clk);
    for (int s = 0; s < n; s++) begin
      @(negedge clk);
      chk("R4",  "ale_o",   32'(ale_o),  32'(exp_q[s].ale));
      chk("R6",  "rd_n_o",  32'(rd_n_o), 32'(exp_q[s].rd_n));
      chk("R6",  "wr_n_o",  32'(wr_n_o), 32'(exp_q[s].wr_n));
      chk("R7",  "cs_n_o",  32'(cs_n_o), 32'(exp_q[s].cs_n));
      chk("R8",  "ad_oe_o", 32'(ad_oe_o), 32'(exp_q[s].oe));
      chk("R10", "ad_o",    32'(ad_o),   32'(exp_q[s].ad));
      chk("R8",  "addr_o",  32'(addr_o), 32'(addr));
      chk("R3",  "req_ready busy", 32'(req_ready), 32'd0);
      chk("R13", "done busy", 32'(done_o), 32'd0);
      // R12: a different request is offered while busy and must be ignored
      req_valid = 1'b1; req_addr = ~addr; req_wdata = ~wd; req_write = !wr;
      req_bus8 = !b8; cfg_ale_ext = !alex; cfg_cmd_dly = !dly; cfg_cyc_time = ~ct;
      cfg_tri_time = ~tf; cfg_rdy_en = !rdy; cfg_demux = !demux;
      if (exp_q[s].sidx >= 0) begin
        ready_i = rdy ? (exp_q[s].sidx >= l0 - 1 + 2 * stall) : 1'b0;  // R11
        ad_i    = (exp_q[s].sidx == lf - 1) ? rv : ~rv;                 // R9
      end else begin
        ready_i = 1'b0;
        ad_i    = ~rv;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) last_rdata = b8 ? {8'h00, rv[7:0]} : rv;
    chk("R13", "done pulse", 32'(done_o), 32'd1);
    chk("R3",  "req_ready at end", 32'(req_ready), 32'd1);
    chk("R9",  "rdata_o", 32'(rdata_o), 32'(last_rdata));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_wdata = '0; req_write = 1'b0;
    req_bus8 = 1'b0; cfg_ale_ext = 1'b0; cfg_cmd_dly = 1'b0; cfg_cyc_time = 4'hF;
    cfg_tri_time = '0; cfg_rdy_en = 1'b0; cfg_demux = 1'b0; ready_i = 1'b0; ad_i = '0;
    last_rdata = 16'h0000;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "ale_o reset",   32'(ale_o),   32'd0);
    chk("R1", "rd_n_o reset",  32'(rd_n_o),  32'd1);
    chk("R1", "wr_n_o reset",  32'(wr_n_o),  32'd1);
    chk("R1", "cs_n_o reset",  32'(cs_n_o),  32'd1);
    chk("R1", "ad_oe_o reset", 32'(ad_oe_o), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);
    chk("R1", "done after reset",      32'(done_o),    32'd0);
    chk("R1", "rdata after reset",     32'(rdata_o),   32'd0);

    // R2: bare cycles, multiplexed 6 steps and demultiplexed 4 steps
    run_cycle(0, 0, 0, 0, 4'hF, 2'd0, 0, 0, 0, 24'h12A5C3, 16'h0000, 16'hBEEF);
    run_cycle(0, 0, 0, 0, 4'hF, 2'd0, 0, 1, 0, 24'h0456E1, 16'h0000, 16'h1234);
    // R3 R4 R5 R6 R10: lengthened latch, command gap, 2 waitstates, tristate 1
    run_cycle(1, 0, 1, 1, 4'hD, 2'd1, 0, 0, 0, 24'hA05A5A, 16'hC0DE, 16'h0000);
    // R10: 8-bit demux write with no tail, drive ends with the cycle
    run_cycle(1, 1, 0, 0, 4'hF, 2'd0, 0, 1, 0, 24'h00FF10, 16'h7E81, 16'h0000);
    // R9: 8-bit multiplexed read with command gap
    run_cycle(0, 1, 0, 1, 4'hE, 2'd0, 0, 0, 0, 24'h333333, 16'h0000, 16'hA9C4);
    // R11: READY low for two samples on a demux read with a waitstate
    run_cycle(0, 0, 0, 0, 4'hE, 2'd2, 1, 1, 2, 24'h5A0001, 16'h0000, 16'h6B2D);
    // R11: READY enabled and high at once on a multiplexed write
    run_cycle(1, 0, 0, 0, 4'hF, 2'd0, 1, 0, 0, 24'h010203, 16'h4455, 16'h0000);
    // R11: READY disabled while held low has no effect
    run_cycle(0, 0, 0, 0, 4'hF, 2'd0, 0, 0, 0, 24'h0F0F0F, 16'h0000, 16'h55AA);
    // R3: demux read, lengthened latch, tristate 3
    run_cycle(0, 0, 1, 0, 4'hC, 2'd3, 0, 1, 0, 24'hFEDCBA, 16'h0000, 16'h0F1E);
    // R11 with a single stall on an 8-bit multiplexed write with gap
    run_cycle(1, 1, 1, 1, 4'hF, 2'd2, 1, 0, 1, 24'h7700EE, 16'h93A7, 16'h0000);

    @(negedge clk);
    chk("R13", "done single pulse", 32'(done_o), 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule